// File: doc/BRIEF.md
# Three-Phase Complementary Gate-Drive Stage

This block turns three per-phase duty values into six gate-drive signals for a three-phase motor bridge: an upper and a lower switch for each of phases U, V and W. A free-running sawtooth carrier is compared with each duty value. A per-phase dead-band unit then delays every turn-on edge by a programmable number of clock cycles, so the two switches of a phase are never on together. A polarity stage maps the logical "switch on" state to a high or a low pin level, with the upper and lower groups set separately.

A sequencer controls when the switches may conduct. It has five states. **ST_IDLE** holds all switches off. **ST_CHARGE** is the bootstrap pre-charge: it drives only the lower switches at half duty for a fixed number of millisecond ticks. **ST_RUN** is normal modulation of all six outputs. **ST_TRIP** is entered while the fault input is high. **ST_HOLDOFF** is the timed retry wait after the fault input has returned low.

The transitions are:
- IDLE→CHARGE when the run request is high and polarity has been written.
- CHARGE→RUN when the pre-charge time has elapsed.
- CHARGE/RUN→IDLE when the run request drops.
- any→TRIP when the fault input is high.
- TRIP→HOLDOFF when the fault input is low.
- HOLDOFF→CHARGE when the retry time has elapsed and the run request and polarity are still present.
- HOLDOFF→IDLE when the retry time has elapsed otherwise.

The dead-time and polarity settings are each accepted once after reset and are locked afterwards.

Top module: `tri_phase_gate_stage`

## Requirements
- R1: While reset is held, and whenever the sequencer is in ST_IDLE, every output sits at its negated level. The negated level is the complement of the group's active level. Before any polarity write, both groups are active-high, so all six outputs are low.
- R2: The carrier counts from 0 to P-1, where P = BASE_PERIOD/(freq_sel+1). Code 0 gives the slowest carrier and code 3 the fastest (four frequencies in ratio 1:2:3:4). A new code takes effect at the next carrier wrap.
- R3: In ST_RUN, a phase's raw upper request is true while carrier < duty. Otherwise its lower request is true. Duty 0 keeps the lower switch on for the whole period. A duty of P or more keeps the upper switch on for the whole period.
- R4: Every switch turn-on is delayed by the dead-time code, counted in clock cycles. In steady state with 0 < duty < P, the upper switch is on for duty−dt cycles per period and the lower switch for P−duty−dt cycles per period. The two switches of a phase are never on in the same cycle.
- R5: The first pulse on dt_wr after reset loads dt_code. Later pulses have no effect until reset.
- R6: The first pulse on pol_wr after reset loads pol_top_hi and pol_bot_hi. A value of 1 means the switch-on level is high; 0 means it is low. Later pulses have no effect until reset.
- R7: A run request is ignored until polarity has been written. Until then the state stays ST_IDLE and no output is asserted.
- R8: Each start enters ST_CHARGE for CHARGE_MS ticks of MS_CYC cycles. During that time the upper outputs stay negated and each lower switch is on while carrier < P/2, less the dead time (P/2−dt cycles per period). ST_RUN follows.
- R9: When fault_in is high, all six outputs are negated in the same cycle and fault_n is low.
- R10: After fault_in returns low, the block waits retry_ms millisecond ticks with outputs negated and fault_n still low. It then restarts through ST_CHARGE if the run request is high and polarity has been written, and otherwise goes to ST_IDLE.
- R11: Dropping the run request returns the block to ST_IDLE with outputs negated. Raising the request again repeats the pre-charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one dead-time step |
| rst_n | input | 1 | Active-low synchronous reset |
| run_cmd | input | 1 | Motor run request (level) |
| fault_in | input | 1 | External fault, active high |
| freq_sel | input | 2 | Carrier frequency code |
| duty_u | input | CNT_W | Phase U duty, in carrier counts |
| duty_v | input | CNT_W | Phase V duty, in carrier counts |
| duty_w | input | CNT_W | Phase W duty, in carrier counts |
| dt_wr | input | 1 | Dead-time write strobe |
| dt_code | input | DT_W | Dead time, in clock cycles |
| pol_wr | input | 1 | Polarity write strobe |
| pol_top_hi | input | 1 | Upper group: 1 means the on level is high |
| pol_bot_hi | input | 1 | Lower group: 1 means the on level is high |
| retry_ms | input | RETRY_W | Retry wait after a fault, in millisecond ticks |
| gate_top | output | 3 | Upper switch drives; bit 0 is U, bit 1 is V, bit 2 is W |
| gate_bot | output | 3 | Lower switch drives; bit 0 is U, bit 1 is V, bit 2 is W |
| fault_n | output | 1 | Low while a fault or its retry wait is active |

## Verification
The bench counts on-cycles per switch over whole carrier periods and compares them with duty−dt and P−duty−dt.

This catches several classes of error:
- A dead-band unit that delays the wrong edge, or none, gives the wrong counts and shows up as cycles where both switches of a phase are on.
- A design that lets a second dead-time or polarity write through gives wrong counts or inverted levels.
- A period decode with the wrong divisor gives wrong counts.

Duty values of 0 and of at least P check that the constant-on cases do not lose a cycle at the wrap.

The start and fault sequences are probed at three points:
- A run request issued before polarity is written. A design that starts anyway toggles the lower switches.
- The cycle in which the fault input rises. A registered fault path leaves one cycle of drive.
- The middle of the retry wait. A design that restarts at once, or skips the pre-charge, shows upper-switch activity.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHARGE,
        ST_RUN,
        ST_TRIP,
        ST_HOLDOFF
    } seq_state_t;
endpackage

// File: rtl/tpg_carrier.sv
module tpg_carrier #(
    parameter int BASE_PERIOD = 1512,
    parameter int CNT_W       = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       freq_sel,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] half
);
    localparam logic [CNT_W-1:0] PER0 = CNT_W'(BASE_PERIOD);
    localparam logic [CNT_W-1:0] PER1 = CNT_W'(BASE_PERIOD / 2);
    localparam logic [CNT_W-1:0] PER2 = CNT_W'(BASE_PERIOD / 3);
    localparam logic [CNT_W-1:0] PER3 = CNT_W'(BASE_PERIOD / 4);

    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] per_sel;

    always_comb begin
        unique case (freq_sel)
            2'd0:    per_sel = PER0;
            2'd1:    per_sel = PER1;
            2'd2:    per_sel = PER2;
            default: per_sel = PER3;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            per_q <= PER0;
        end else if (cnt >= per_q - 1'b1) begin
            cnt   <= '0;
            per_q <= per_sel;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign half = per_q >> 1;

    // R2
    carrier_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < per_q);
endmodule

// File: rtl/tpg_deadband.sv
module tpg_deadband #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw,
    input  logic [DT_W-1:0] dt,
    output logic            hi_act,
    output logic            lo_act
);
    logic            raw_q;
    logic [DT_W-1:0] dly;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
            dly   <= '0;
        end else if (raw != raw_q) begin
            raw_q <= raw;
            dly   <= dt;
        end else if (dly != '0) begin
            dly <= dly - 1'b1;
        end
    end

    assign hi_act = raw_q  && (dly == '0);
    assign lo_act = !raw_q && (dly == '0);

    // R4
    turn_on_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dt) != '0 && $rose(hi_act)) |-> !$past(lo_act));
endmodule

// File: rtl/tpg_sequencer.sv
module tpg_sequencer
    import tpg_pkg::*;
#(
    parameter int MS_CYC    = 8000,
    parameter int CHARGE_MS = 100,
    parameter int RETRY_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_cmd,
    input  logic               pol_set,
    input  logic               fault_in,
    input  logic [RETRY_W-1:0] retry_ms,
    output logic               top_en,
    output logic               bot_en,
    output logic               charge,
    output logic               fault_n
);
    localparam int PRE_W  = (MS_CYC > 1) ? $clog2(MS_CYC) : 1;
    localparam int CHG_W  = $clog2(CHARGE_MS + 1);
    localparam int MS_W   = ((RETRY_W > CHG_W) ? RETRY_W : CHG_W) + 1;

    seq_state_t       state_q, state_nx;
    logic [PRE_W-1:0] pre;
    logic [MS_W-1:0]  ms;
    logic             go_ok;

    assign go_ok = run_cmd && pol_set;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        if (fault_in) begin
            state_nx = ST_TRIP;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (go_ok) state_nx = ST_CHARGE;
                ST_CHARGE:  if (!run_cmd) state_nx = ST_IDLE;
                            else if (ms >= MS_W'(CHARGE_MS)) state_nx = ST_RUN;
                ST_RUN:     if (!run_cmd) state_nx = ST_IDLE;
                ST_TRIP:    state_nx = ST_HOLDOFF;
                ST_HOLDOFF: if (ms >= MS_W'(retry_ms))
                                state_nx = go_ok ? ST_CHARGE : ST_IDLE;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_nx != state_q) begin
            pre <= '0;
            ms  <= '0;
        end else if (pre == PRE_W'(MS_CYC - 1)) begin
            pre <= '0;
            if (ms != '1) ms <= ms + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    always_comb begin
        top_en  = 1'b0;
        bot_en  = 1'b0;
        charge  = 1'b0;
        fault_n = !fault_in;
        unique case (state_q)
            ST_IDLE:    ;
            ST_CHARGE:  begin bot_en = 1'b1; charge = 1'b1; end
            ST_RUN:     begin bot_en = 1'b1; top_en = 1'b1; end
            ST_TRIP:    fault_n = 1'b0;
            ST_HOLDOFF: fault_n = 1'b0;
            default:    ;
        endcase
    end

    // R7
    charge_needs_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_IDLE && state_q == ST_CHARGE) |-> $past(pol_set));

    // R9
    fault_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |=> (state_q == ST_TRIP));

    // R10
    holdoff_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLDOFF) |-> !fault_n);
endmodule

// File: rtl/tri_phase_gate_stage.sv
module tri_phase_gate_stage #(
    parameter int BASE_PERIOD = 1512,
    parameter int MS_CYC      = 8000,
    parameter int CHARGE_MS   = 100,
    parameter int RETRY_W     = 8,
    parameter int DT_W        = 8,
    localparam int CNT_W      = $clog2(BASE_PERIOD + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_cmd,
    input  logic               fault_in,
    input  logic [1:0]         freq_sel,
    input  logic [CNT_W-1:0]   duty_u,
    input  logic [CNT_W-1:0]   duty_v,
    input  logic [CNT_W-1:0]   duty_w,
    input  logic               dt_wr,
    input  logic [DT_W-1:0]    dt_code,
    input  logic               pol_wr,
    input  logic               pol_top_hi,
    input  logic               pol_bot_hi,
    input  logic [RETRY_W-1:0] retry_ms,
    output logic [2:0]         gate_top,
    output logic [2:0]         gate_bot,
    output logic               fault_n
);
    logic [DT_W-1:0]  dt_q;
    logic             dt_locked, pol_set, pol_top_q, pol_bot_q;
    logic [CNT_W-1:0] cnt, half;
    logic             top_en, bot_en, charge;
    logic [CNT_W-1:0] duty_a [3];
    logic [2:0]       hi_act, lo_act, top_on, bot_on;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dt_q      <= '0;
            dt_locked <= 1'b0;
            pol_set   <= 1'b0;
            pol_top_q <= 1'b1;
            pol_bot_q <= 1'b1;
        end else begin
            if (dt_wr && !dt_locked) begin
                dt_q      <= dt_code;
                dt_locked <= 1'b1;
            end
            if (pol_wr && !pol_set) begin
                pol_top_q <= pol_top_hi;
                pol_bot_q <= pol_bot_hi;
                pol_set   <= 1'b1;
            end
        end
    end

    tpg_carrier #(.BASE_PERIOD(BASE_PERIOD), .CNT_W(CNT_W)) u_carrier (
        .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .cnt(cnt), .half(half)
    );

    tpg_sequencer #(.MS_CYC(MS_CYC), .CHARGE_MS(CHARGE_MS), .RETRY_W(RETRY_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .pol_set(pol_set),
        .fault_in(fault_in), .retry_ms(retry_ms), .top_en(top_en),
        .bot_en(bot_en), .charge(charge), .fault_n(fault_n)
    );

    assign duty_a[0] = duty_u;
    assign duty_a[1] = duty_v;
    assign duty_a[2] = duty_w;

    for (genvar ph = 0; ph < 3; ph++) begin : g_phase
        logic raw;
        always_comb begin
            if (charge)      raw = (cnt >= half);
            else if (top_en) raw = (cnt < duty_a[ph]);
            else             raw = 1'b0;
        end

        tpg_deadband #(.DT_W(DT_W)) u_db (
            .clk(clk), .rst_n(rst_n), .raw(raw), .dt(dt_q),
            .hi_act(hi_act[ph]), .lo_act(lo_act[ph])
        );

        assign top_on[ph]   = hi_act[ph] && top_en && !fault_in;
        assign bot_on[ph]   = lo_act[ph] && bot_en && !fault_in;
        assign gate_top[ph] = ~(top_on[ph] ^ pol_top_q);
        assign gate_bot[ph] = ~(bot_on[ph] ^ pol_bot_q);
    end

    // R4
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_on & bot_on) == 3'b000);

    // R5
    dt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dt_locked) |-> $stable(dt_q));

    // R6
    pol_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pol_set) |-> ($stable(pol_top_q) && $stable(pol_bot_q)));

    // R8
    charge_top_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        charge |-> (gate_top == {3{~pol_top_q}}));

    // R9
    fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |-> (gate_top == {3{~pol_top_q}} && gate_bot == {3{~pol_bot_q}} && !fault_n));
endmodule

// File: tb/tri_phase_gate_stage_test.sv
module tri_phase_gate_stage_test;
    localparam int BP    = 48;
    localparam int MSC   = 16;
    localparam int CHG   = 12;
    localparam int CNT_W = $clog2(BP + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_cmd = 1'b0, fault_in = 1'b0;
    logic [1:0]       freq_sel = 2'd0;
    logic [CNT_W-1:0] duty_u = '0, duty_v = '0, duty_w = '0;
    logic             dt_wr = 1'b0, pol_wr = 1'b0;
    logic [7:0]       dt_code = '0;
    logic             pol_top_hi = 1'b1, pol_bot_hi = 1'b1;
    logic [7:0]       retry_ms = 8'd3;
    logic [2:0]       gate_top, gate_bot;
    logic             fault_n;

    int vecs = 0, miss = 0;
    bit pt = 1'b1, pb = 1'b1;
    int dt_exp = 0;
    int topc[3], botc[3], ovl;

    always #5 clk = ~clk;

    tri_phase_gate_stage #(.BASE_PERIOD(BP), .MS_CYC(MSC), .CHARGE_MS(CHG)) uut (
        .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .fault_in(fault_in),
        .freq_sel(freq_sel), .duty_u(duty_u), .duty_v(duty_v), .duty_w(duty_w),
        .dt_wr(dt_wr), .dt_code(dt_code), .pol_wr(pol_wr),
        .pol_top_hi(pol_top_hi), .pol_bot_hi(pol_bot_hi), .retry_ms(retry_ms),
        .gate_top(gate_top), .gate_bot(gate_bot), .fault_n(fault_n)
    );

    function automatic int per_of(input int sel);
        return BP / (sel + 1);
    endfunction
    function automatic int exp_top(input int d, input int p, input int dt);
        if (d == 0) return 0;
        if (d >= p) return p;
        return d - dt;
    endfunction
    function automatic int exp_bot(input int d, input int p, input int dt);
        if (d == 0) return p;
        if (d >= p) return 0;
        return p - d - dt;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            miss++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int n);
        for (int i = 0; i < 3; i++) begin topc[i] = 0; botc[i] = 0; end
        ovl = 0;
        for (int c = 0; c < n; c++) begin
            @(posedge clk); #2;
            for (int i = 0; i < 3; i++) begin
                if (gate_top[i] == pt) topc[i]++;
                if (gate_bot[i] == pb) botc[i]++;
                if (gate_top[i] == pt && gate_bot[i] == pb) ovl++;
            end
        end
    endtask

    task automatic check_charge(input string req);
        measure(2 * BP);
        for (int i = 0; i < 3; i++) begin
            check(topc[i] == 0, {req, " upper off in pre-charge"}, topc[i], 0);
            check(botc[i] == 2 * (BP / 2 - dt_exp), {req, " lower half duty"},
                  botc[i], 2 * (BP / 2 - dt_exp));
        end
    endtask

    task automatic check_run(input string req, input int sel, input int du, input int dv, input int dw);
        int p;
        int d[3];
        p = per_of(sel);
        d[0] = du; d[1] = dv; d[2] = dw;
        measure(2 * p);
        for (int i = 0; i < 3; i++) begin
            check(topc[i] == 2 * exp_top(d[i], p, dt_exp), {req, " upper on-count"},
                  topc[i], 2 * exp_top(d[i], p, dt_exp));
            check(botc[i] == 2 * exp_bot(d[i], p, dt_exp), {req, " lower on-count"},
                  botc[i], 2 * exp_bot(d[i], p, dt_exp));
        end
        check(ovl == 0, "R4 no overlap", ovl, 0);
    endtask

    task automatic apply(input int sel, input int du, input int dv, input int dw);
        @(negedge clk);
        freq_sel = sel[1:0];
        duty_u = CNT_W'(du); duty_v = CNT_W'(dv); duty_w = CNT_W'(dw);
        cycles(BP + 3 * per_of(sel));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miss++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        cycles(3);
        // R1 reset state
        check(gate_top == 3'b000, "R1 upper during reset", gate_top, 0);
        check(gate_bot == 3'b000, "R1 lower during reset", gate_bot, 0);
        check(fault_n == 1'b1, "R1 fault_n during reset", fault_n, 1);
        @(negedge clk); rst_n = 1'b1;

        // R7 run request before polarity is ignored
        @(negedge clk); run_cmd = 1'b1;
        cycles(5);
        measure(100);
        for (int i = 0; i < 3; i++) begin
            check(topc[i] == 0, "R7 upper idle without polarity", topc[i], 0);
            check(botc[i] == 0, "R7 lower idle without polarity", botc[i], 0);
        end

        // R5 dead time: first write wins
        @(negedge clk); dt_code = 8'd2; dt_wr = 1'b1;
        @(negedge clk); dt_code = 8'd5;
        @(negedge clk); dt_wr = 1'b0;
        dt_exp = 2;
        // R6 polarity: upper active high, lower active low, second write ignored
        @(negedge clk); pol_top_hi = 1'b1; pol_bot_hi = 1'b0; pol_wr = 1'b1;
        @(negedge clk); pol_top_hi = 1'b0; pol_bot_hi = 1'b1;
        @(negedge clk); pol_wr = 1'b0;
        pt = 1'b1; pb = 1'b0;

        // R8 pre-charge on first start
        cycles(20);
        check_charge("R8");
        cycles(250);

        // R3 R4 R5 R6 directed: mid duty, zero, full
        apply(0, 20, 0, BP);
        check_run("R3", 0, 20, 0, BP);
        apply(3, per_of(3), 0, 6);
        check_run("R3", 3, per_of(3), 0, 6);

        // R2 R4 random carrier codes and duties
        for (int k = 0; k < 16; k++) begin
            int sel, p, du, dv, dw;
            sel = $urandom % 4;
            p = per_of(sel);
            du = 3 + $urandom % (p - 5);
            dv = 3 + $urandom % (p - 5);
            dw = 3 + $urandom % (p - 5);
            apply(sel, du, dv, dw);
            check_run("R2", sel, du, dv, dw);
        end

        // R9 fault blocks at once
        apply(0, 30, 10, 24);
        @(negedge clk); fault_in = 1'b1;
        #1;
        check(gate_top == 3'b000, "R9 upper negated same cycle", gate_top, 0);
        check(gate_bot == 3'b111, "R9 lower negated same cycle", gate_bot, 7);
        check(fault_n == 1'b0, "R9 fault_n low", fault_n, 0);
        measure(10);
        for (int i = 0; i < 3; i++)
            check(topc[i] + botc[i] == 0, "R9 held off during fault", topc[i] + botc[i], 0);

        // R10 retry wait then pre-charge restart
        @(negedge clk); fault_in = 1'b0;
        cycles(20);
        check(fault_n == 1'b0, "R10 fault_n low in retry wait", fault_n, 0);
        check(gate_top == 3'b000 && gate_bot == 3'b111, "R10 outputs negated in retry wait",
              {gate_top, gate_bot}, 7);
        cycles(60);
        check(fault_n == 1'b1, "R10 fault_n released", fault_n, 1);
        check_charge("R10");
        cycles(250);
        check_run("R10", 0, 30, 10, 24);

        // R11 stop then restart repeats pre-charge
        @(negedge clk); run_cmd = 1'b0;
        cycles(3);
        measure(50);
        for (int i = 0; i < 3; i++)
            check(topc[i] + botc[i] == 0, "R11 stopped outputs negated", topc[i] + botc[i], 0);
        check(gate_top == 3'b000 && gate_bot == 3'b111, "R1 idle negated levels",
              {gate_top, gate_bot}, 7);
        @(negedge clk); run_cmd = 1'b1;
        cycles(20);
        check_charge("R11");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end
endmodule